// File: doc/BRIEF.md
# Planar Framebuffer Merge and Readback Datapath

This block sits between a host byte port and four parallel byte-wide memory planes that all share one address. On a host write it produces one byte for each plane, built from the host byte, a per-plane constant, the plane bytes captured by the last host read, a logic operation and a bit mask. It also produces a write enable for each plane. On a host read it returns either one chosen plane byte or a per-bit colour-match result, and it captures all four plane bytes into a 32-bit holding latch for later writes.

Software programs eight small control registers through a separate configuration strobe. Address decode, the memory array and any interleaved addressing schemes are outside the block. The caller presents the plane bytes for the addressed location on `plane_rdata` in the same cycle as the read strobe.

Top module: `planar_rw_datapath`

## Requirements
- R1: While `rst_n` is low and after it is released, every control register, the holding latch, `plane_we`, `plane_wdata` and `host_rdata` are zero.
- R2: A configuration write with `cfg_wr`=1 updates one register at the next clock edge, and that register acts from the following cycle on. The registers by `cfg_idx` are: 0 per-plane constant bits[3:0]; 1 constant-substitute enable bits[3:0]; 2 compare colour bits[3:0]; 3 rotate count bits[2:0] and logic op bits[4:3]; 4 read plane select bits[1:0]; 5 write mode bits[1:0] and read mode bit[2]; 6 compare care bits[3:0]; 7 bit mask bits[7:0]. Bit n of a 4-bit field belongs to plane n.
- R3: Write mode 0 rotates the host byte right by the rotate count. A plane whose substitute-enable bit is 1 uses its constant bit copied to all 8 bits in place of that rotated byte.
- R4: In write modes 0, 2 and 3 the plane source byte goes through the logic op with the plane's latch byte before masking: 0 pass, 1 AND, 2 OR, 3 XOR.
- R5: In write modes 0 and 2, a result bit whose bit-mask bit is 1 takes the logic op output, and one whose mask bit is 0 takes the latch bit.
- R6: Write mode 1 writes each plane with its latch byte and ignores the logic op and the bit mask.
- R7: Write mode 2 uses, for plane n, eight copies of host data bit n as the source byte.
- R8: Write mode 3 uses each plane's expanded constant whatever the substitute enables hold. The mask applied is the bit mask ANDed with the rotated host byte.
- R9: One cycle after a cycle with `host_wr`=1, `plane_we` equals the `plane_en` of that cycle and `plane_wdata` holds the merged bytes, with plane n at bits [8n+7:8n]. After a cycle without a write, `plane_we` is zero and `plane_wdata` keeps its value.
- R10: In read mode 0, one cycle after `host_rd`, `host_rdata` is the byte of the plane chosen by the read plane select.
- R11: In read mode 1, bit i of the returned byte is 1 when every plane whose care bit is 1 has bit i equal to its compare colour bit. A plane with care bit 0 is excluded, so all care bits zero give 0xFF. The read plane select has no effect in this mode.
- R12: Each host read loads all four plane bytes into the latch. Without a read, the latch and `host_rdata` keep their values.
- R13: When `host_wr` and `host_rd` occur in the same cycle, the write uses the latch from before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_data | input | 8 | Configuration write data |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| plane_rdata | input | 32 | Plane bytes at the addressed location, plane n at [8n+7:8n] |
| plane_en | input | 4 | Per-plane write permission |
| plane_we | output | 4 | Per-plane write enable, one cycle after the host write |
| plane_wdata | output | 32 | Merged per-plane write bytes |
| host_rdata | output | 8 | Byte returned for the last host read |

## Verification
The assertions assume that `plane_rdata` carries valid data for the addressed location in every cycle where `host_rd` is high. They assume nothing about how host and configuration strobes combine, so any of them may coincide. The stimulus changes every input only just after a falling edge and gives `plane_rdata` a fresh random value each cycle. The strobes are freely mixed, including a write and a read in one cycle and a configuration change in the same cycle as a write, which stays inside what the checks expect.

// File: rtl/plane_pkg.sv
`timescale 1ns/1ps
package plane_pkg;

   localparam int CFG_IDX_W = 3;

   typedef enum logic [1:0] {
      WM_SUBST  = 2'd0,
      WM_LATCH  = 2'd1,
      WM_SPLAT  = 2'd2,
      WM_MASKED = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      FN_PASS = 2'd0,
      FN_AND  = 2'd1,
      FN_OR   = 2'd2,
      FN_XOR  = 2'd3
   } alu_e;

   localparam logic [CFG_IDX_W-1:0] IX_CONST     = 3'd0;
   localparam logic [CFG_IDX_W-1:0] IX_SUBST_EN  = 3'd1;
   localparam logic [CFG_IDX_W-1:0] IX_CMP_COLOR = 3'd2;
   localparam logic [CFG_IDX_W-1:0] IX_ROT_FN    = 3'd3;
   localparam logic [CFG_IDX_W-1:0] IX_RD_SEL    = 3'd4;
   localparam logic [CFG_IDX_W-1:0] IX_MODES     = 3'd5;
   localparam logic [CFG_IDX_W-1:0] IX_CMP_CARE  = 3'd6;
   localparam logic [CFG_IDX_W-1:0] IX_BITMASK   = 3'd7;

endpackage

// File: rtl/pw_ctrl_regs.sv
`timescale 1ns/1ps
module pw_ctrl_regs
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   localparam int ROT_W = $clog2(BYTE_W),
   localparam int SEL_W = $clog2(PLANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [BYTE_W-1:0]    cfg_data,
   output logic [PLANES-1:0]    const_bits,
   output logic [PLANES-1:0]    subst_en,
   output logic [PLANES-1:0]    cmp_color,
   output logic [PLANES-1:0]    cmp_care,
   output logic [ROT_W-1:0]     rot,
   output alu_e                 fn,
   output logic [SEL_W-1:0]     rd_sel,
   output wmode_e               wmode,
   output logic                 rmode,
   output logic [BYTE_W-1:0]    bitmask
);

   localparam int FN_LSB = ROT_W;
   localparam int RM_BIT = 2;

   logic [PLANES-1:0] plane_fields [4];
   logic              unused_cfg_bits;

   assign unused_cfg_bits = ^cfg_data;

   // the four plane-wide fields share one write path
   for (genvar f = 0; f < 4; f++) begin : g_plane_field
      localparam logic [CFG_IDX_W-1:0] FIELD_IX =
         (f == 0) ? IX_CONST :
         (f == 1) ? IX_SUBST_EN :
         (f == 2) ? IX_CMP_COLOR : IX_CMP_CARE;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            plane_fields[f] <= '0;
         end else if (cfg_wr && cfg_idx == FIELD_IX) begin
            plane_fields[f] <= cfg_data[PLANES-1:0];
         end
      end
   end

   assign const_bits = plane_fields[0];
   assign subst_en   = plane_fields[1];
   assign cmp_color  = plane_fields[2];
   assign cmp_care   = plane_fields[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rot     <= '0;
         fn      <= FN_PASS;
         rd_sel  <= '0;
         wmode   <= WM_SUBST;
         rmode   <= 1'b0;
         bitmask <= '0;
      end else if (cfg_wr) begin
         case (cfg_idx)
            IX_ROT_FN: begin
               rot <= cfg_data[ROT_W-1:0];
               fn  <= alu_e'(cfg_data[FN_LSB+1:FN_LSB]);
            end
            IX_RD_SEL:  rd_sel  <= cfg_data[SEL_W-1:0];
            IX_MODES: begin
               wmode <= wmode_e'(cfg_data[1:0]);
               rmode <= cfg_data[RM_BIT];
            end
            IX_BITMASK: bitmask <= cfg_data;
            default: ;
         endcase
      end
   end

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable({const_bits, subst_en, cmp_color, cmp_care,
                           rot, fn, rd_sel, wmode, rmode, bitmask}));

   // R2
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_idx == IX_BITMASK) |=> bitmask == $past(cfg_data));

endmodule

// File: rtl/pw_write_stage.sv
`timescale 1ns/1ps
module pw_write_stage
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   localparam int ROT_W  = $clog2(BYTE_W),
   localparam int DATA_W = PLANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic [PLANES-1:0] plane_en,
   input  logic [DATA_W-1:0] latch,
   input  logic [PLANES-1:0] const_bits,
   input  logic [PLANES-1:0] subst_en,
   input  logic [ROT_W-1:0]  rot,
   input  alu_e              fn,
   input  wmode_e            wmode,
   input  logic [BYTE_W-1:0] bitmask,
   output logic [PLANES-1:0] plane_we,
   output logic [DATA_W-1:0] plane_wdata
);

   logic [2*BYTE_W-1:0] rot_wide;
   logic [BYTE_W-1:0]   rot_data;
   logic [BYTE_W-1:0]   eff_mask;
   logic [DATA_W-1:0]   merged;
   logic                unused_rot_hi;

   // one rotator shared by every plane
   assign rot_wide      = {host_wdata, host_wdata} >> rot;
   assign rot_data      = rot_wide[BYTE_W-1:0];
   assign unused_rot_hi = ^rot_wide[2*BYTE_W-1:BYTE_W];

   assign eff_mask = (wmode == WM_MASKED) ? (bitmask & rot_data) : bitmask;

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [BYTE_W-1:0] lat_b;
      logic [BYTE_W-1:0] src_b;
      logic [BYTE_W-1:0] alu_b;

      assign lat_b = latch[p*BYTE_W +: BYTE_W];

      always_comb begin
         case (wmode)
            WM_SUBST:  src_b = subst_en[p] ? {BYTE_W{const_bits[p]}} : rot_data;
            WM_LATCH:  src_b = lat_b;
            WM_SPLAT:  src_b = {BYTE_W{host_wdata[p]}};
            default:   src_b = {BYTE_W{const_bits[p]}};
         endcase
      end

      always_comb begin
         case (fn)
            FN_AND:  alu_b = src_b & lat_b;
            FN_OR:   alu_b = src_b | lat_b;
            FN_XOR:  alu_b = src_b ^ lat_b;
            default: alu_b = src_b;
         endcase
      end

      assign merged[p*BYTE_W +: BYTE_W] = (wmode == WM_LATCH) ? lat_b :
         ((alu_b & eff_mask) | (lat_b & ~eff_mask));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plane_we    <= '0;
         plane_wdata <= '0;
      end else begin
         plane_we <= host_wr ? plane_en : '0;
         if (host_wr) begin
            plane_wdata <= merged;
         end
      end
   end

   // R9
   we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> plane_we == $past(plane_en));

   // R9
   we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> (plane_we == '0) && $stable(plane_wdata));

   // R6
   latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && wmode == WM_LATCH) |=> plane_wdata == $past(latch));

   // R5
   keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && (wmode == WM_SUBST || wmode == WM_SPLAT)) |=>
         ((plane_wdata ^ $past(latch)) & ~{PLANES{$past(bitmask)}}) == '0);

endmodule

// File: rtl/pw_read_path.sv
`timescale 1ns/1ps
module pw_read_path #(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   localparam int SEL_W  = $clog2(PLANES),
   localparam int DATA_W = PLANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] plane_rdata,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rmode,
   input  logic [PLANES-1:0] cmp_color,
   input  logic [PLANES-1:0] cmp_care,
   output logic [DATA_W-1:0] latch,
   output logic [BYTE_W-1:0] host_rdata
);

   logic [BYTE_W-1:0] sel_byte;
   logic [BYTE_W-1:0] cmp_byte;

   assign sel_byte = plane_rdata[int'(rd_sel)*BYTE_W +: BYTE_W];

   // per bit position: gather that bit across planes and compare
   for (genvar i = 0; i < BYTE_W; i++) begin : g_bitpos
      logic [PLANES-1:0] col_bits;
      for (genvar p = 0; p < PLANES; p++) begin : g_gather
         assign col_bits[p] = plane_rdata[p*BYTE_W + i];
      end
      assign cmp_byte[i] = &(~cmp_care | ~(col_bits ^ cmp_color));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch      <= '0;
         host_rdata <= '0;
      end else if (host_rd) begin
         latch      <= plane_rdata;
         host_rdata <= rmode ? cmp_byte : sel_byte;
      end
   end

   // R12
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> latch == $past(plane_rdata));

   // R12
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata) && $stable(latch));

   // R11
   care_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rmode && cmp_care == '0) |=> host_rdata == '1);

endmodule

// File: rtl/planar_rw_datapath.sv
`timescale 1ns/1ps
module planar_rw_datapath
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   localparam int ROT_W  = $clog2(BYTE_W),
   localparam int SEL_W  = $clog2(PLANES),
   localparam int DATA_W = PLANES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [BYTE_W-1:0]    cfg_data,
   input  logic                 host_wr,
   input  logic [BYTE_W-1:0]    host_wdata,
   input  logic                 host_rd,
   input  logic [DATA_W-1:0]    plane_rdata,
   input  logic [PLANES-1:0]    plane_en,
   output logic [PLANES-1:0]    plane_we,
   output logic [DATA_W-1:0]    plane_wdata,
   output logic [BYTE_W-1:0]    host_rdata
);

   if (PLANES < 2 || (1 << SEL_W) != PLANES) begin : g_bad_planes
      $error("PLANES must be a power of two and at least 2");
   end
   if (PLANES > BYTE_W) begin : g_bad_splat
      $error("PLANES may not exceed BYTE_W");
   end
   if ((1 << ROT_W) != BYTE_W || ROT_W + 2 > BYTE_W) begin : g_bad_byte
      $error("BYTE_W must be a power of two wide enough for rotate and op fields");
   end

   logic [PLANES-1:0] const_bits;
   logic [PLANES-1:0] subst_en;
   logic [PLANES-1:0] cmp_color;
   logic [PLANES-1:0] cmp_care;
   logic [ROT_W-1:0]  rot;
   alu_e              fn;
   logic [SEL_W-1:0]  rd_sel;
   wmode_e            wmode;
   logic              rmode;
   logic [BYTE_W-1:0] bitmask;
   logic [DATA_W-1:0] latch;

   pw_ctrl_regs #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_idx    (cfg_idx),
      .cfg_data   (cfg_data),
      .const_bits (const_bits),
      .subst_en   (subst_en),
      .cmp_color  (cmp_color),
      .cmp_care   (cmp_care),
      .rot        (rot),
      .fn         (fn),
      .rd_sel     (rd_sel),
      .wmode      (wmode),
      .rmode      (rmode),
      .bitmask    (bitmask)
   );

   pw_write_stage #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_write (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_wdata  (host_wdata),
      .plane_en    (plane_en),
      .latch       (latch),
      .const_bits  (const_bits),
      .subst_en    (subst_en),
      .rot         (rot),
      .fn          (fn),
      .wmode       (wmode),
      .bitmask     (bitmask),
      .plane_we    (plane_we),
      .plane_wdata (plane_wdata)
   );

   pw_read_path #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_read (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_rd     (host_rd),
      .plane_rdata (plane_rdata),
      .rd_sel      (rd_sel),
      .rmode       (rmode),
      .cmp_color   (cmp_color),
      .cmp_care    (cmp_care),
      .latch       (latch),
      .host_rdata  (host_rdata)
   );

   // R13
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_rd && wmode == WM_LATCH) |=>
         plane_wdata == $past(latch) && latch == $past(plane_rdata));

   // R1
   reset_out_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> plane_we == '0 && host_rdata == '0 && plane_wdata == '0);

endmodule

// File: tb/planar_rw_datapath_tb_top.sv
`timescale 1ns/1ps
module planar_rw_datapath_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [2:0]  cfg_idx;
   logic [7:0]  cfg_data;
   logic        host_wr;
   logic [7:0]  host_wdata;
   logic        host_rd;
   logic [31:0] plane_rdata;
   logic [3:0]  plane_en;
   logic [3:0]  plane_we;
   logic [31:0] plane_wdata;
   logic [7:0]  host_rdata;

   always #5 clk = ~clk;

   planar_rw_datapath dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .plane_rdata(plane_rdata), .plane_en(plane_en),
      .plane_we(plane_we), .plane_wdata(plane_wdata), .host_rdata(host_rdata)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // reference model state
   logic [3:0]  m_const, m_subst, m_color, m_care;
   logic [2:0]  m_rot;
   logic [1:0]  m_fn, m_sel, m_wm;
   logic        m_rm;
   logic [7:0]  m_mask;
   logic [7:0]  m_lat [4];
   logic [3:0]  e_we;
   logic [31:0] e_wd;
   logic [7:0]  e_rd;

   function automatic logic [7:0] rotr(input logic [7:0] d, input int r);
      logic [15:0] t;
      t = {d, d} >> r;
      return t[7:0];
   endfunction

   function automatic logic [7:0] fill(input logic b);
      return b ? 8'hFF : 8'h00;
   endfunction

   always @(posedge clk) begin
      logic [7:0] v, m, lb, rd;
      if (!rst_n) begin
         m_const = 0; m_subst = 0; m_color = 0; m_care = 0;
         m_rot = 0; m_fn = 0; m_sel = 0; m_wm = 0; m_rm = 0; m_mask = 0;
         for (int p = 0; p < 4; p++) m_lat[p] = 0;
         e_we = 0; e_wd = 0; e_rd = 0;
      end else begin
         // write uses state from before this edge
         if (host_wr) begin
            for (int p = 0; p < 4; p++) begin
               lb = m_lat[p];
               case (m_wm)
                  2'd0: v = m_subst[p] ? fill(m_const[p]) : rotr(host_wdata, m_rot);
                  2'd1: v = lb;
                  2'd2: v = fill(host_wdata[p]);
                  default: v = fill(m_const[p]);
               endcase
               if (m_wm != 2'd1) begin
                  case (m_fn)
                     2'd1: v = v & lb;
                     2'd2: v = v | lb;
                     2'd3: v = v ^ lb;
                     default: ;
                  endcase
                  m = (m_wm == 2'd3) ? (m_mask & rotr(host_wdata, m_rot)) : m_mask;
                  v = (v & m) | (lb & ~m);
               end
               e_wd[p*8 +: 8] = v;
            end
            e_we = plane_en;
         end else begin
            e_we = 0;
         end
         if (host_rd) begin
            if (!m_rm) begin
               rd = plane_rdata[m_sel*8 +: 8];
            end else begin
               for (int i = 0; i < 8; i++) begin
                  rd[i] = 1'b1;
                  for (int p = 0; p < 4; p++)
                     if (m_care[p] && plane_rdata[p*8+i] != m_color[p]) rd[i] = 1'b0;
               end
            end
            e_rd = rd;
            for (int p = 0; p < 4; p++) m_lat[p] = plane_rdata[p*8 +: 8];
         end
         if (cfg_wr) begin
            case (cfg_idx)
               3'd0: m_const = cfg_data[3:0];
               3'd1: m_subst = cfg_data[3:0];
               3'd2: m_color = cfg_data[3:0];
               3'd3: begin m_rot = cfg_data[2:0]; m_fn = cfg_data[4:3]; end
               3'd4: m_sel = cfg_data[1:0];
               3'd5: begin m_wm = cfg_data[1:0]; m_rm = cfg_data[2]; end
               3'd6: m_care = cfg_data[3:0];
               default: m_mask = cfg_data;
            endcase
         end
      end
   end

   task automatic compare();
      checks++;
      if (plane_we !== e_we || plane_wdata !== e_wd || host_rdata !== e_rd) begin
         fails++;
         $display("FAIL %s: we=%h exp %h wdata=%h exp %h rdata=%h exp %h",
                  cur_req, plane_we, e_we, plane_wdata, e_wd, host_rdata, e_rd);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle_inputs();
      cfg_wr = 0; host_wr = 0; host_rd = 0;
      plane_rdata = $urandom;
   endtask

   task automatic cfg(input logic [2:0] idx, input logic [7:0] d);
      cfg_wr = 1; cfg_idx = idx; cfg_data = d;
      plane_rdata = $urandom;
      tick();
      idle_inputs();
   endtask

   task automatic op(input bit wr, input bit rd, input logic [7:0] d,
                     input logic [31:0] pd, input logic [3:0] en);
      host_wr = wr; host_rd = rd; host_wdata = d; plane_rdata = pd; plane_en = en;
      tick();
      idle_inputs();
      tick();
   endtask

   task automatic rw_burst(input int n);
      for (int k = 0; k < n; k++) begin
         op(0, 1, 8'h00, $urandom, 4'hF);
         op(1, 0, 8'($urandom), $urandom, 4'($urandom));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired (all requirements)");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_idx = 0; cfg_data = 0; host_wdata = 0; plane_en = 4'hF;
      idle_inputs();
      // R1: reset state
      cur_req = "R1";
      host_wr = 1; host_rd = 1; cfg_wr = 1;
      tick(); tick();
      idle_inputs();
      tick();
      rst_n = 1;
      tick(); tick();

      // R3: rotation and constant substitution
      cur_req = "R3";
      cfg(3'd7, 8'hFF);
      cfg(3'd5, 8'h00);
      for (int r = 0; r < 8; r++) begin
         cfg(3'd3, 8'(r));
         cfg(3'd0, 8'($urandom));
         cfg(3'd1, 8'($urandom));
         rw_burst(2);
      end
      cfg(3'd1, 8'h0F);
      cfg(3'd0, 8'h05);
      rw_burst(1);

      // R4: logic operations against latch
      cur_req = "R4";
      cfg(3'd1, 8'h00);
      for (int f = 1; f < 4; f++) begin
         cfg(3'd3, 8'((f << 3) | 3));
         rw_burst(3);
         cfg(3'd5, 8'h02);
         rw_burst(2);
         cfg(3'd5, 8'h00);
      end

      // R5: bit mask keeps latch bits
      cur_req = "R5";
      cfg(3'd3, 8'h00);
      cfg(3'd7, 8'h00);
      rw_burst(2);
      for (int k = 0; k < 6; k++) begin
         cfg(3'd7, 8'($urandom));
         cfg(3'd5, 8'(k[0] ? 2 : 0));
         rw_burst(2);
      end

      // R6: latch copy, op and mask ignored
      cur_req = "R6";
      cfg(3'd5, 8'h01);
      cfg(3'd3, 8'h1D);
      cfg(3'd7, 8'h3C);
      rw_burst(4);

      // R7: data bit splat
      cur_req = "R7";
      cfg(3'd5, 8'h02);
      cfg(3'd3, 8'h00);
      cfg(3'd7, 8'hFF);
      op(1, 0, 8'h0A, 32'h0, 4'hF);
      op(1, 0, 8'h05, 32'h0, 4'hF);
      rw_burst(3);

      // R8: masked constant mode
      cur_req = "R8";
      cfg(3'd5, 8'h03);
      cfg(3'd1, 8'h00);
      cfg(3'd0, 8'h09);
      for (int k = 0; k < 6; k++) begin
         cfg(3'd3, 8'($urandom));
         cfg(3'd7, 8'($urandom));
         rw_burst(2);
      end

      // R9: plane enable gating and write timing
      cur_req = "R9";
      op(1, 0, 8'hA5, 32'h0, 4'h0);
      op(1, 0, 8'h5A, 32'h0, 4'h6);
      op(0, 0, 8'hFF, 32'h0, 4'hF);

      // R10: plane select readback
      cur_req = "R10";
      cfg(3'd5, 8'h00);
      for (int s = 0; s < 4; s++) begin
         cfg(3'd4, 8'(s));
         op(0, 1, 8'h00, 32'h44332211, 4'hF);
         op(0, 1, 8'h00, $urandom, 4'hF);
      end

      // R11: colour compare
      cur_req = "R11";
      cfg(3'd5, 8'h04);
      cfg(3'd6, 8'h00);
      op(0, 1, 8'h00, $urandom, 4'hF);
      cfg(3'd6, 8'h0F);
      cfg(3'd2, 8'h05);
      op(0, 1, 8'h00, 32'h00FF00FF, 4'hF);
      op(0, 1, 8'h00, 32'h00FF00F0, 4'hF);
      for (int k = 0; k < 6; k++) begin
         cfg(3'd6, 8'($urandom));
         cfg(3'd2, 8'($urandom));
         cfg(3'd4, 8'($urandom));
         op(0, 1, 8'h00, $urandom, 4'hF);
      end

      // R12: latch and readback hold without reads
      cur_req = "R12";
      cfg(3'd5, 8'h01);
      op(0, 1, 8'h00, 32'hCAFEF00D, 4'hF);
      for (int k = 0; k < 3; k++) op(1, 0, 8'($urandom), $urandom, 4'hF);

      // R13: same-cycle write and read
      cur_req = "R13";
      op(1, 1, 8'h00, 32'h12345678, 4'hF);
      op(1, 0, 8'h00, 32'h0, 4'hF);
      cfg(3'd5, 8'h00);
      cfg(3'd3, 8'h18);
      op(1, 1, 8'h3C, 32'hFFFFFFFF, 4'hF);

      // R2: configuration change coinciding with a write
      cur_req = "R2";
      cfg(3'd7, 8'h0F);
      host_wr = 1; host_wdata = 8'hFF; cfg_wr = 1; cfg_idx = 3'd7; cfg_data = 8'hF0;
      tick();
      idle_inputs();
      op(1, 0, 8'hFF, 32'h0, 4'hF);

      // mixed traffic over all requirements
      cur_req = "R2 mixed";
      for (int k = 0; k < 3000; k++) begin
         cfg_wr = 1'($urandom); cfg_idx = 3'($urandom); cfg_data = 8'($urandom);
         host_wr = 1'($urandom); host_rd = 1'($urandom);
         host_wdata = 8'($urandom); plane_rdata = $urandom; plane_en = 4'($urandom);
         tick();
      end
      idle_inputs();
      tick();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule